// File: doc/BRIEF.md
# Multi-level fair bus requester

This block asks for a shared backplane bus on behalf of one local master. It uses one of several request levels, four by default. A local request pulse, or the software hold bit, starts a request on the selected level. When the grant for that level comes in while the bus is free, the block takes the bus: it drives bus-busy and drops its request. It gives the bus back under one of two release policies. Grants for levels it is not requesting are handed on down the daisy chain.

The configuration arrives as plain register bits:
- a level field;
- a release-policy bit;
- a fair-mode bit;
- a hold bit.

The block has no data path, so every pin is a plain control or status level. There is no valid/ready handshake.

Before the state machine sees any backplane line, the line passes through a two-flop synchronizer. Backplane inputs are active low. The drive outputs `req_drv` and `busy_drv` are active high, and a 1 means "pull the shared line low". The grant-out chain stays active low.

Top module: `bus_level_requester`

## Requirements
- R1: `cfg_level` value n (0..3) selects request level n: while requesting, exactly bit n of `req_drv` is 1 and all other bits are 0.
- R2: A new `cfg_level` value is taken over only while the block owns the bus (`busy_drv`=1). A change made at any other time leaves the level already in force unchanged.
- R3: With `cfg_rel_done`=1 and `cfg_hold`=0, the block keeps the bus until `loc_done` ends the transfer it acquired the bus for, then deasserts `busy_drv`. If the bus was acquired by the hold bit alone, it is released as soon as `cfg_hold` clears.
- R4: With `cfg_rel_done`=0 and `cfg_hold`=0, the block keeps the bus until some backplane request line is seen low. `loc_done` has no effect on ownership in this mode.
- R5: With `cfg_fair`=1, a pending request is not driven until the backplane request line of the selected level is seen high (inactive). With `cfg_fair`=0, the request is driven at once.
- R6: While `cfg_hold`=1, the block requests the bus and keeps it, whatever the release policy. `has_bus`=1 exactly when the bus is owned with `cfg_hold`=1, and it returns to 0 once `cfg_hold` clears.
- R7: The bus is acquired when the grant for the selected level is low, the block is requesting, and `bus_busy_n` is high. The block then sets `busy_drv`=1 and clears `req_drv`. While `bus_busy_n` is low, no grant is accepted.
- R8: A grant on a level the block is not requesting is copied to `grant_out_n` of that level one clock after its synchronized value changes. While the block owns the bus, or while it requests on that level, `grant_out_n` stays high.
- R9: After `busy_drv` falls, `req_drv` stays 0 for at least one clock before any new request.
- R10: Reset leaves the block idle with `req_drv`=0, `busy_drv`=0, `has_bus`=0, `grant_out_n` all 1, and the level in force equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req_n | input | 4 | Backplane request lines, active low, one per level |
| bus_gnt_in_n | input | 4 | Daisy-chain grant inputs, active low, one per level |
| bus_busy_n | input | 1 | Backplane bus-busy line, active low |
| loc_req | input | 1 | One-clock pulse: local master wants the bus |
| loc_done | input | 1 | One-clock pulse: local transfer finished |
| cfg_level | input | 2 | Requested level (taken over only while owning the bus) |
| cfg_fair | input | 1 | 1 = fair mode |
| cfg_rel_done | input | 1 | 1 = release when done, 0 = release on request |
| cfg_hold | input | 1 | 1 = acquire and keep the bus |
| req_drv | output | 4 | Request drive per level, 1 pulls the line low |
| busy_drv | output | 1 | Bus-busy drive, 1 pulls the line low |
| grant_out_n | output | 4 | Daisy-chain grant outputs, active low |
| has_bus | output | 1 | Bus held because of the hold bit |

## Verification
The hardest situation to reach is a level change that must not take effect. The field is written while the block is idle, and the bench must show that the next request still goes out on the old level. Only after an ownership period may the new level appear. The stimulus table runs that sequence in order, with a full acquire and release in between. The minimum idle gap is reached by re-arming a local request while the bus is still owned, then releasing the bus through another requester's line. The bench walks the output cycle by cycle across the release.

// File: rtl/brq_pkg.sv
package brq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FAIRW = 3'd1,
    ST_REQ   = 3'd2,
    ST_OWN   = 3'd3,
    ST_GAP   = 3'd4
  } rq_state_e;
endpackage

// File: rtl/brq_sync.sv
module brq_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= RST_VAL;
    else        pipe[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[k] <= RST_VAL;
      else        pipe[k] <= pipe[k-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/brq_fsm.sv
module brq_fsm
  import brq_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int SETTLE = 3,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int SC_W  = $clog2(SETTLE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] lines_s,
  input  logic [LEVELS-1:0] gnt_s,
  input  logic              busy_s,
  input  logic              loc_req,
  input  logic              loc_done,
  input  logic [LVL_W-1:0]  cfg_level,
  input  logic              cfg_fair,
  input  logic              cfg_rel_done,
  input  logic              cfg_hold,
  output rq_state_e         state_q,
  output logic [LVL_W-1:0]  lvl_q,
  output logic [LEVELS-1:0] req_drv,
  output logic              busy_drv,
  output logic              has_bus
);
  rq_state_e       state_d;
  logic            want_q, open_q;
  logic [SC_W-1:0] settle_q;
  logic            take, other_req, release_now;

  // acquisition: own grant seen, requesting, bus not busy
  assign take      = (state_q == ST_REQ) && !gnt_s[lvl_q] && busy_s;
  assign other_req = ~&lines_s;
  assign release_now = !cfg_hold &&
                       (cfg_rel_done ? !open_q : (other_req && settle_q == '0));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (want_q || cfg_hold) state_d = cfg_fair ? ST_FAIRW : ST_REQ;
      ST_FAIRW: if (lines_s[lvl_q])     state_d = ST_REQ;
      ST_REQ:   if (take)               state_d = ST_OWN;
      ST_OWN:   if (release_now)        state_d = ST_GAP;
      ST_GAP:                           state_d = ST_IDLE;
      default:                          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      want_q   <= 1'b0;
      open_q   <= 1'b0;
      settle_q <= '0;
      lvl_q    <= '0;
      has_bus  <= 1'b0;
    end else begin
      state_q <= state_d;
      want_q  <= (want_q && !take) || loc_req;
      if (take)                                open_q <= want_q;
      else if (state_q == ST_OWN && loc_done) open_q <= 1'b0;
      if (take)                  settle_q <= SC_W'(SETTLE);
      else if (settle_q != '0)   settle_q <= settle_q - 1'b1;
      if (state_q == ST_OWN)     lvl_q <= cfg_level;
      has_bus <= cfg_hold && (state_d == ST_OWN);
    end
  end

  for (genvar i = 0; i < LEVELS; i++) begin : g_req
    assign req_drv[i] = (state_q == ST_REQ) && (lvl_q == LVL_W'(i));
  end
  assign busy_drv = (state_q == ST_OWN);

  // R1
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_drv));
  // R7
  req_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_drv && (|req_drv)));
  // R2
  lvl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_OWN) |=> (lvl_q == $past(lvl_q)));
  // R9
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_drv) && !busy_drv) |-> (req_drv == '0));
  // R6
  has_bus_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    has_bus |-> busy_drv);
  // R6
  has_bus_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_hold |=> !has_bus);
endmodule

// File: rtl/brq_gpass.sv
module brq_gpass
  import brq_pkg::*;
#(
  parameter int LEVELS = 4,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] gnt_s,
  input  rq_state_e         state_q,
  input  logic [LVL_W-1:0]  lvl_q,
  output logic [LEVELS-1:0] grant_out_n
);
  for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
    logic keep;
    assign keep = (state_q == ST_OWN) ||
                  ((state_q == ST_REQ) && (lvl_q == LVL_W'(i)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) grant_out_n[i] <= 1'b1;
      else        grant_out_n[i] <= keep ? 1'b1 : gnt_s[i];
    end
  end

  // R8
  no_pass_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OWN) |=> (&grant_out_n));
endmodule

// File: rtl/bus_level_requester.sv
module bus_level_requester
  import brq_pkg::*;
#(
  parameter int LEVELS      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE      = 3,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] bus_req_n,
  input  logic [LEVELS-1:0] bus_gnt_in_n,
  input  logic              bus_busy_n,
  input  logic              loc_req,
  input  logic              loc_done,
  input  logic [LVL_W-1:0]  cfg_level,
  input  logic              cfg_fair,
  input  logic              cfg_rel_done,
  input  logic              cfg_hold,
  output logic [LEVELS-1:0] req_drv,
  output logic              busy_drv,
  output logic [LEVELS-1:0] grant_out_n,
  output logic              has_bus
);
  logic [LEVELS-1:0] lines_s, gnt_s;
  logic              busy_s;
  rq_state_e         state_q;
  logic [LVL_W-1:0]  lvl_q;

  brq_sync #(.W(LEVELS), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync_req (
    .clk(clk), .rst_n(rst_n), .d(bus_req_n), .q(lines_s));
  brq_sync #(.W(LEVELS), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync_gnt (
    .clk(clk), .rst_n(rst_n), .d(bus_gnt_in_n), .q(gnt_s));
  brq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_busy (
    .clk(clk), .rst_n(rst_n), .d(bus_busy_n), .q(busy_s));

  brq_fsm #(.LEVELS(LEVELS), .SETTLE(SETTLE)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .lines_s(lines_s), .gnt_s(gnt_s), .busy_s(busy_s),
    .loc_req(loc_req), .loc_done(loc_done),
    .cfg_level(cfg_level), .cfg_fair(cfg_fair),
    .cfg_rel_done(cfg_rel_done), .cfg_hold(cfg_hold),
    .state_q(state_q), .lvl_q(lvl_q),
    .req_drv(req_drv), .busy_drv(busy_drv), .has_bus(has_bus));

  brq_gpass #(.LEVELS(LEVELS)) u_gpass (
    .clk(clk), .rst_n(rst_n), .gnt_s(gnt_s),
    .state_q(state_q), .lvl_q(lvl_q), .grant_out_n(grant_out_n));
endmodule

// File: tb/bus_level_requester_tb_top.sv
module bus_level_requester_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE_WAIT = 6;

  typedef struct packed {
    logic [3:0] rq;
    logic [1:0] lvl;
    logic       fair, rwd, hold, bsy_n;
    logic [3:0] lines_n, gnt_n;
    logic       preq, pdone;
    logic [3:0] e_req;
    logic       e_busy, e_has;
    logic [3:0] e_gout;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{4'd10, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'hF, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 4'hF}, // R10 idle
    '{4'd8,  2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'hD, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 4'hD}, // R8 pass lvl1
    '{4'd1,  2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'hF, 1'b1, 1'b0, 4'h1, 1'b0, 1'b0, 4'hF}, // R1 req lvl0
    '{4'd7,  2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'hE, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 4'hF}, // R7 acquire
    '{4'd3,  2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'hF, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 4'hF}, // R3 keep
    '{4'd3,  2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'hF, 1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 4'hF}, // R3 done
    '{4'd2,  2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'hF, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 4'hF}, // R2 write idle
    '{4'd2,  2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'hF, 1'b1, 1'b0, 4'h1, 1'b0, 1'b0, 4'hF}, // R2 old lvl
    '{4'd8,  2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'hE, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 4'hF}, // R8 own
    '{4'd3,  2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'hF, 1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 4'hF}, // R3
    '{4'd2,  2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'hF, 1'b1, 1'b0, 4'h4, 1'b0, 1'b0, 4'hF}, // R2 new lvl
    '{4'd7,  2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'hB, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 4'hF}, // R7
    '{4'd4,  2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 4'hF, 1'b0, 1'b1, 4'h0, 1'b1, 1'b0, 4'hF}, // R4 done ign
    '{4'd4,  2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 4'h7, 4'hF, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 4'hF}, // R4 release
    '{4'd5,  2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 4'hB, 4'hF, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 4'hF}, // R5 wait
    '{4'd5,  2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 4'hF, 1'b0, 1'b0, 4'h4, 1'b0, 1'b0, 4'hF}, // R5 go
    '{4'd7,  2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 4'hB, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 4'hF}, // R7
    '{4'd6,  2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 4'hF, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 4'hF}, // R6 has
    '{4'd6,  2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 4'hB, 4'hF, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 4'hF}, // R6 keep
    '{4'd6,  2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 4'hB, 4'hF, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 4'hF}, // R6 clear
    '{4'd6,  2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 4'hF, 1'b0, 1'b0, 4'h4, 1'b0, 1'b0, 4'hF}, // R6 hold req
    '{4'd6,  2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 4'hB, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 4'hF}, // R6
    '{4'd3,  2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'hF, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 4'hF}, // R3 hold only
    '{4'd7,  2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 4'hF, 4'hF, 1'b1, 1'b0, 4'h4, 1'b0, 1'b0, 4'hF}, // R7
    '{4'd7,  2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 4'hF, 4'hB, 1'b0, 1'b0, 4'h4, 1'b0, 1'b0, 4'hF}, // R7 busy
    '{4'd7,  2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'hB, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 4'hF}, // R7 free
    '{4'd3,  2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'hF, 1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 4'hF}  // R3
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_req_n = 4'hF, bus_gnt_in_n = 4'hF;
  logic       bus_busy_n = 1'b1, loc_req = 1'b0, loc_done = 1'b0;
  logic [1:0] cfg_level = 2'd0;
  logic       cfg_fair = 1'b0, cfg_rel_done = 1'b0, cfg_hold = 1'b0;
  logic [3:0] req_drv, grant_out_n;
  logic       busy_drv, has_bus;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_level_requester dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req_n(bus_req_n), .bus_gnt_in_n(bus_gnt_in_n),
    .bus_busy_n(bus_busy_n), .loc_req(loc_req), .loc_done(loc_done),
    .cfg_level(cfg_level), .cfg_fair(cfg_fair), .cfg_rel_done(cfg_rel_done),
    .cfg_hold(cfg_hold), .req_drv(req_drv), .busy_drv(busy_drv),
    .grant_out_n(grant_out_n), .has_bus(has_bus));

  task automatic chk(input string rq, input logic [9:0] got, input logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {req,busy,has,gout} got %b expected %b", rq, got, exp);
    end
  endtask

  function automatic logic [9:0] outs();
    return {req_drv, busy_drv, has_bus, grant_out_n};
  endfunction

  task automatic pulse_req();
    @(negedge clk); loc_req = 1'b1;
    @(negedge clk); loc_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    bit gap_ok, seen_fall, seen_rise;
    repeat (3) @(negedge clk);
    chk("R10 in reset", outs(), {4'h0, 1'b0, 1'b0, 4'hF});
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      cfg_level = VECS[v].lvl;  cfg_fair = VECS[v].fair;
      cfg_rel_done = VECS[v].rwd; cfg_hold = VECS[v].hold;
      bus_busy_n = VECS[v].bsy_n; bus_req_n = VECS[v].lines_n;
      bus_gnt_in_n = VECS[v].gnt_n;
      loc_req = VECS[v].preq; loc_done = VECS[v].pdone;
      @(negedge clk);
      loc_req = 1'b0; loc_done = 1'b0;
      repeat (SETTLE_WAIT) @(negedge clk);
      chk($sformatf("R%0d vector %0d", VECS[v].rq, v), outs(),
          {VECS[v].e_req, VECS[v].e_busy, VECS[v].e_has, VECS[v].e_gout});
    end

    // R9: re-arm a request while owning, then release by another request
    cfg_rel_done = 1'b0; cfg_fair = 1'b0; cfg_hold = 1'b0;
    pulse_req();
    repeat (SETTLE_WAIT) @(negedge clk);
    bus_gnt_in_n = 4'hB;
    repeat (SETTLE_WAIT) @(negedge clk);
    bus_gnt_in_n = 4'hF;
    chk("R9 owning before release", outs(), {4'h0, 1'b1, 1'b0, 4'hF});
    pulse_req();
    repeat (SETTLE_WAIT) @(negedge clk);
    @(negedge clk); bus_req_n = 4'hE;
    @(negedge clk); bus_req_n = 4'hF;
    gap_ok = 1'b1; seen_fall = 1'b0; seen_rise = 1'b0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (!seen_fall && !busy_drv) begin
        seen_fall = 1'b1;
        if (req_drv != 4'h0) gap_ok = 1'b0;
      end else if (seen_fall && req_drv == 4'h4) seen_rise = 1'b1;
    end
    chk("R9 gap after release", {8'h0, gap_ok, seen_rise}, {8'h0, 1'b1, 1'b1});

    // R10: reset while requesting returns level to 0
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset mid-request", outs(), {4'h0, 1'b0, 1'b0, 4'hF});
    @(negedge clk); rst_n = 1'b1;
    pulse_req();
    repeat (SETTLE_WAIT) @(negedge clk);
    chk("R10 level back to 0", outs(), {4'h1, 1'b0, 1'b0, 4'hF});

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule